// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block is a register-mapped pulse-width modulator with four independent output channels. Software reaches it over a plain 32-bit register bus with a byte offset, a write strobe with write data, and a read strobe with read data. Each channel has three settings: a 6-bit prescaler that divides the input clock into counter ticks, a 16-bit period count that gives the cycle length in ticks, and a 16-bit duty count that gives the active time in ticks. The per-channel enable, polarity and drive-type bits for all four channels are grouped by function in one shared control word.

To reprogram a channel, software first clears its enable bit. It then writes the prescale, period and duty values and sets the enable bit again. The block copies the channel's settings into working registers when the enable bit goes from 0 to 1. Writes made while the channel is running therefore leave the current waveform unchanged. Each new run starts with the active phase. The bus has no handshake: every access completes in one cycle, so there is no back-pressure.

Top module: `quad_pwm_unit`

## Requirements
- R1: After reset, the control word reads 0x00000F00: polarity bits 11:8 are set, and enable bits 3:0 and drive-type bits 18:15 are clear. The period, duty and prescale registers read 0, and all four outputs are low.
- R2: Register map and read port. The control word is at offset 0x00, with the enable for channel ch at bit ch, its polarity at bit 8+ch and its drive type at bit 15+ch. The 16-bit period for channel ch is at offset 0x04+8*ch and the 16-bit duty is at offset 0x08+8*ch. A read returns the last value written, with unused bits as zero. Read data appears on the clock edge after the read strobe and is zero after any cycle without a read.
- R3: The prescale register is at offset 0x24. Channel ch's 6-bit field sits at bits (3-ch)*6+5 down to (3-ch)*6, so channel 0 uses bits 23:18 and channel 3 uses bits 5:0. Bits 31:24 read as zero.
- R4: A running channel repeats a cycle of (prescale+1)*period input clocks. The first (prescale+1)*duty clocks of each cycle are active. The first active clock is the second clock edge after the edge that writes the enable bit.
- R5: A duty count of 0 keeps the output inactive for the whole cycle. A duty count greater than or equal to the period count keeps it active for the whole cycle.
- R6: With polarity 1 the active level is high and the inactive level is low. With polarity 0 both levels are inverted. A polarity change takes effect at once, even on a running channel.
- R7: While a channel's enable bit is clear, its output sits at the inactive level and its counters are held at zero. Enabling it again starts a fresh cycle from the beginning.
- R8: Period, duty and prescale are captured when the enable bit rises. Writes to them while the channel runs do not change its waveform until the next enable.
- R9: The drive-type bits are stored and read back only. They have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and counters |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| pwm_out | output | 4 | PWM outputs, bit ch for channel ch |

## Verification
The hardest case to reach from the ports is a channel whose register values no longer match the waveform it is producing: a duty or period write lands while the channel is running. The bench enables a channel, then rewrites its duty with a different value mid-run. It measures a full window of whole cycles, whose active-clock count does not depend on phase, so it still sees the old duty. After a disable and re-enable it then sees the new value. The vector loop places each prescale value in a different channel's field, so a swapped field order would show up as a wrong cycle length.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int NCH    = 4;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  // Bit offsets inside the shared control word
  localparam int EN_LSB  = 0;
  localparam int POL_LSB = 8;
  localparam int TYP_LSB = 15;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_PRE  = 6'h24;

  function automatic logic [ADDR_W-1:0] per_off(input int ch);
    return ADDR_W'(4 + 8 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] duty_off(input int ch);
    return ADDR_W'(8 + 8 * ch);
  endfunction
endpackage

// File: rtl/qpwm_regs.sv
module qpwm_regs
  import qpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    en_o,
  output logic [NCH-1:0]    pol_o,
  output logic [NCH-1:0]    typ_o,
  output logic [CNT_W-1:0]  per_o  [NCH],
  output logic [CNT_W-1:0]  duty_o [NCH],
  output logic [PRE_W-1:0]  pre_o  [NCH]
);
  localparam int PRE_BITS = NCH * PRE_W;

  logic [NCH-1:0]      en_q, pol_q, typ_q;
  logic [PRE_BITS-1:0] pre_q;
  logic [DATA_W-1:0]   rd_mux, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '1;
      typ_q <= '0;
      pre_q <= '0;
    end else if (we) begin
      if (addr == OFF_CTRL) begin
        en_q  <= wdata[EN_LSB  +: NCH];
        pol_q <= wdata[POL_LSB +: NCH];
        typ_q <= wdata[TYP_LSB +: NCH];
      end
      if (addr == OFF_PRE) pre_q <= wdata[PRE_BITS-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CNT_W-1:0] per_q, duty_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        per_q  <= '0;
        duty_q <= '0;
      end else if (we) begin
        if (addr == per_off(c))  per_q  <= wdata[CNT_W-1:0];
        if (addr == duty_off(c)) duty_q <= wdata[CNT_W-1:0];
      end
    end
    assign per_o[c]  = per_q;
    assign duty_o[c] = duty_q;
    // fields are packed in reverse channel order
    assign pre_o[c]  = pre_q[(NCH-1-c)*PRE_W +: PRE_W];
  end

  always_comb begin
    rd_mux = '0;
    if (addr == OFF_CTRL) begin
      rd_mux[EN_LSB  +: NCH] = en_q;
      rd_mux[POL_LSB +: NCH] = pol_q;
      rd_mux[TYP_LSB +: NCH] = typ_q;
    end
    if (addr == OFF_PRE) rd_mux[PRE_BITS-1:0] = pre_q;
    for (int c = 0; c < NCH; c++) begin
      if (addr == per_off(c))  rd_mux[CNT_W-1:0] = per_o[c];
      if (addr == duty_off(c)) rd_mux[CNT_W-1:0] = duty_o[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= re ? rd_mux : '0;
  end

  assign rdata = rdata_q;
  assign en_o  = en_q;
  assign pol_o = pol_q;
  assign typ_o = typ_q;
endmodule

// File: rtl/qpwm_tick.sv
module qpwm_tick #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PRE_W-1:0] lim,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr)         cnt_q <= '0;
    else if (cnt_q == lim) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick = !clr && (cnt_q == lim);
endmodule

// File: rtl/qpwm_chan.sv
module qpwm_chan #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol,
  input  logic [CNT_W-1:0] per_in,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [PRE_W-1:0] pre_in,
  output logic             pwm
);
  logic             run_q;
  logic [CNT_W-1:0] per_w, duty_w, cyc_q;
  logic [PRE_W-1:0] pre_w;
  logic             start, tick, wrap, active;

  assign start = en && !run_q;
  assign wrap  = ({1'b0, cyc_q} + 1'b1) >= {1'b0, per_w};

  qpwm_tick #(.PRE_W(PRE_W)) tick_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!run_q),
    .lim  (pre_w),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      per_w  <= '0;
      duty_w <= '0;
      pre_w  <= '0;
      cyc_q  <= '0;
    end else begin
      run_q <= en;
      if (start) begin
        per_w  <= per_in;
        duty_w <= duty_in;
        pre_w  <= pre_in;
        cyc_q  <= '0;
      end else if (!run_q || !en) begin
        cyc_q <= '0;
      end else if (tick) begin
        cyc_q <= wrap ? '0 : cyc_q + 1'b1;
      end
    end
  end

  assign active = run_q && (cyc_q < duty_w);
  assign pwm    = active ? pol : !pol;
endmodule

// File: rtl/quad_pwm_unit.sv
module quad_pwm_unit
  import qpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0]   en_bits, pol_bits, type_bits;
  logic [CNT_W-1:0] per_v  [NCH];
  logic [CNT_W-1:0] duty_v [NCH];
  logic [PRE_W-1:0] pre_v  [NCH];

  qpwm_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .re    (bus_re),
    .rdata (bus_rdata),
    .en_o  (en_bits),
    .pol_o (pol_bits),
    .typ_o (type_bits),
    .per_o (per_v),
    .duty_o(duty_v),
    .pre_o (pre_v)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    qpwm_chan #(.CNT_W(CNT_W), .PRE_W(PRE_W)) chan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_bits[c]),
      .pol    (pol_bits[c]),
      .per_in (per_v[c]),
      .duty_in(duty_v[c]),
      .pre_in (pre_v[c]),
      .pwm    (pwm_out[c])
    );
  end
endmodule

// File: rtl/qpwm_chk.sv
module qpwm_chk
  import qpwm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    en_bits,
  input logic [NCH-1:0]    pol_bits
);
  for (genvar c = 0; c < NCH; c++) begin : g_idle
    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_bits[c] && !$past(en_bits[c])) |-> (pwm_out[c] == !pol_bits[c]));
  end

  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_re) |-> (bus_rdata == '0));

  assert_pre_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_re) && $past(bus_addr) == OFF_PRE) |-> (bus_rdata[31:24] == 8'h00));

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_we) && $past(bus_addr) == OFF_CTRL) |->
      (en_bits == $past(bus_wdata[EN_LSB +: NCH])));
endmodule

bind quad_pwm_unit qpwm_chk chk_i (.*);

// File: tb/quad_pwm_unit_tb.sv
module quad_pwm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  quad_pwm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  typedef struct packed {
    int ch; int pre; int per; int duty; int pol; int act;
  } vec_t;

  // act = expected active clocks in one full cycle of (pre+1)*per clocks
  localparam vec_t VECS [5] = '{
    '{0, 0, 4, 1, 1, 1},
    '{1, 2, 5, 2, 1, 6},
    '{2, 1, 3, 5, 1, 6},
    '{3, 2, 6, 0, 0, 0},
    '{0, 3, 2, 1, 0, 4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic prog(input int ch, input int pre, input int per, input int duty,
                      input int pol, input logic [31:0] extra);
    logic [31:0] polm;
    polm = 32'h0F00;
    if (pol == 0) polm &= ~(32'h1 << (8 + ch));
    wr(6'h00, 32'h0F00 | extra);
    wr(6'h24, 32'(pre) << ((3 - ch) * 6));
    wr(6'(4 + 8 * ch), 32'(per));
    wr(6'(8 + 8 * ch), 32'(duty));
    wr(6'h00, polm | extra | (32'h1 << ch));
  endtask

  task automatic meas(input int ch, input int n, input int pol, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch] == pol[0]) cnt++;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 outputs", {28'h0, pwm_out}, 32'h0);
    rd(6'h00, d); chk("R1 ctrl", d, 32'h0000_0F00);
    rd(6'h24, d); chk("R1 prescale", d, 32'h0);
    rd(6'h04, d); chk("R1 period0", d, 32'h0);

    // R2 / R3 readback
    wr(6'h0C, 32'hABCD_1234); rd(6'h0C, d); chk("R2 period1", d, 32'h0000_1234);
    wr(6'h20, 32'h0000_FFFF); rd(6'h20, d); chk("R2 duty3", d, 32'h0000_FFFF);
    @(negedge clk); chk("R2 rdata idle", bus_rdata, 32'h0);
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, d); chk("R3 prescale bits", d, 32'h00FF_FFFF);
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, d); chk("R2 ctrl bits", d, 32'h0007_8F0F);
    wr(6'h00, 32'h0000_0F00);
    wr(6'h24, 32'h0);

    // R4 R5 R3 vector table
    for (int i = 0; i < 5; i++) begin
      prog(VECS[i].ch, VECS[i].pre, VECS[i].per, VECS[i].duty, VECS[i].pol, 32'h0);
      meas(VECS[i].ch, (VECS[i].pre + 1) * VECS[i].per, VECS[i].pol, cnt);
      chk($sformatf("R4 R5 R3 vector %0d active clocks", i), 32'(cnt), 32'(VECS[i].act));
    end

    // R4 first clock active right after enable, disabled outputs inactive (R7)
    prog(0, 0, 4, 1, 1, 32'h0);
    @(negedge clk); chk("R4 first clock active", {31'h0, pwm_out[0]}, 32'h1);
    wr(6'h00, 32'h0000_0B00);
    @(negedge clk); chk("R7 inverted idle high", {31'h0, pwm_out[2]}, 32'h1);
    chk("R7 normal idle low", {31'h0, pwm_out[0]}, 32'h0);

    // R8 capture on enable, R7 restart
    prog(1, 0, 4, 2, 1, 32'h0);
    meas(1, 4, 1, cnt); chk("R8 initial duty", 32'(cnt), 32'd2);
    wr(6'h10, 32'd4);
    meas(1, 4, 1, cnt); chk("R8 running write ignored", 32'(cnt), 32'd2);
    wr(6'h00, 32'h0000_0F00);
    @(negedge clk); chk("R7 disabled inactive", {31'h0, pwm_out[1]}, 32'h0);
    wr(6'h00, 32'h0000_0F02);
    meas(1, 4, 1, cnt); chk("R8 new duty after re-enable", 32'(cnt), 32'd4);
    // R6 polarity flip on running channel
    wr(6'h00, 32'h0000_0D02);
    chk("R6 live polarity", {31'h0, pwm_out[1]}, 32'h0);

    // R9 drive-type bits have no effect
    prog(0, 0, 4, 1, 1, 32'h0007_8000);
    meas(0, 4, 1, cnt); chk("R9 type set waveform", 32'(cnt), 32'd1);
    rd(6'h00, d); chk("R9 type readback", d, 32'h0007_8F01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule